// File: doc/BRIEF.md
# Operand Forwarding and Load Interlock Unit

This block resolves data hazards for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute (shift and ALU), buffer/data memory, and write-back. Every cycle it looks at the instruction in decode. It takes that instruction's source register numbers for up to three operand buses, with a read-enable for each bus. It compares each source number against the destination of the instruction in each later stage. It then tells the datapath where each operand must come from. The choices are the execute-stage ALU result, the result held in the memory/buffer stage, the value on the write-back bus, or the register file.

One case cannot be covered by forwarding. A load in execute has its data only at the end of the data-memory stage. If the decode instruction reads that loaded register, the unit raises a stall for fetch and decode and a bubble-insert for execute, for exactly one cycle. The bubble carries write-enable low. One cycle later the load sits in the memory stage and its data is forwarded from there. Register 15 holds the program counter and is never forwarded. A read of it is flagged so that the datapath supplies the decode-stage PC+8 value.

The unit is purely combinational. The data multiplexers, the register file and the pipeline registers belong to the surrounding datapath.

Top module: `operand_bypass_ctrl`

## Requirements
- R1: An enabled operand whose source equals the execute-stage destination, with that stage's write-enable high, gets select code 1 (execute-stage result). Operand i's select is on `fwd_sel[i]`.
- R2: An enabled operand that matches only the memory-stage destination, with its write-enable high, gets select code 2 (memory-stage result). This also covers a load that has reached the memory stage.
- R3: An enabled operand that matches only the write-back destination, with its write-enable high, gets select code 3 (write-back bus).
- R4: When several stages match, the youngest producer wins: execute beats memory, and memory beats write-back.
- R5: A stage whose write-enable is low never matches, whatever its destination number is.
- R6: Source register 15 is never forwarded. Its operand gets select code 0 and its `pc_rd` bit is set. A destination of 15 matches no operand and raises no stall.
- R7: If the execute stage holds a load (`ex_load` high, write-enable high) whose destination matches an enabled operand, then `stall_fd` and `bubble_ex` are both high.
- R8: A load in the memory stage never stalls. Its consumer is forwarded with code 2 in the cycle after the one-cycle stall.
- R9: An operand with its read-enable low gets select code 0 and a clear `pc_rd` bit, and it never causes a stall.
- R10: The three operands are resolved independently. Each one can take a different source in the same cycle.
- R11: With no match in any stage, all selects are 0 (register file) and there is no stall. With all inputs zero, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NSRC x RW (3x4) | Source register number per operand of the decode instruction |
| dec_rd_en | input | NSRC (3) | Operand is actually read |
| ex_dst | input | RW (4) | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RW (4) | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | RW (4) | Destination register of the write-back instruction |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_sel | output | NSRC x 2 (3x2) | Per-operand source: 0 register file/PC, 1 execute, 2 memory, 3 write-back |
| pc_rd | output | NSRC (3) | Operand reads the program counter (supply PC+8) |
| stall_fd | output | 1 | Hold the fetch and decode pipeline registers |
| bubble_ex | output | 1 | Load a no-op with write-enable low into execute |

## Verification
The unit has no state, so a wrong match or a wrong priority shows up at `fwd_sel` in the same cycle in which the inputs present the hazard. In a full pipeline, the wrong select would put a stale or younger-but-wrong value into the ALU operand in the next cycle. A missing interlock is just as immediate: `stall_fd` stays low while a load-use pair is present, and the consumer would read the pre-load register value. The bench therefore checks every output combinationally after each input change. It also walks the load-use pair across two cycles to see the stall followed by memory-stage forwarding.

// File: rtl/operand_bypass_ctrl.sv
module operand_bypass_ctrl #(
  parameter int RW     = 4,
  parameter int NSRC   = 3,
  parameter int PC_IDX = 15
) (
  input  logic [NSRC-1:0][RW-1:0] dec_src,
  input  logic [NSRC-1:0]         dec_rd_en,
  input  logic [RW-1:0]           ex_dst,
  input  logic                    ex_we,
  input  logic                    ex_load,
  input  logic [RW-1:0]           mem_dst,
  input  logic                    mem_we,
  input  logic [RW-1:0]           wb_dst,
  input  logic                    wb_we,
  output logic [NSRC-1:0][1:0]    fwd_sel,
  output logic [NSRC-1:0]         pc_rd,
  output logic                    stall_fd,
  output logic                    bubble_ex
);
  localparam logic [1:0]    SEL_RF  = 2'd0;
  localparam logic [1:0]    SEL_EX  = 2'd1;
  localparam logic [1:0]    SEL_MEM = 2'd2;
  localparam logic [1:0]    SEL_WB  = 2'd3;
  localparam logic [RW-1:0] PC_NUM  = RW'(PC_IDX);

  wire ex_live  = ex_we  && (ex_dst  != PC_NUM);
  wire mem_live = mem_we && (mem_dst != PC_NUM);
  wire wb_live  = wb_we  && (wb_dst  != PC_NUM);

  logic [NSRC-1:0] use_stall;

  for (genvar i = 0; i < NSRC; i++) begin : g_opnd
    wire is_pc  = dec_src[i] == PC_NUM;
    wire live   = dec_rd_en[i] && !is_pc;
    wire hit_ex = live && ex_live  && (ex_dst  == dec_src[i]);
    wire hit_m  = live && mem_live && (mem_dst == dec_src[i]);
    wire hit_w  = live && wb_live  && (wb_dst  == dec_src[i]);

    assign fwd_sel[i]   = hit_ex ? SEL_EX  :
                          hit_m  ? SEL_MEM :
                          hit_w  ? SEL_WB  : SEL_RF;
    assign pc_rd[i]     = dec_rd_en[i] && is_pc;
    assign use_stall[i] = hit_ex && ex_load;
  end

  assign stall_fd  = |use_stall;
  assign bubble_ex = stall_fd;
endmodule

module operand_bypass_ctrl_chk #(
  parameter int RW     = 4,
  parameter int NSRC   = 3,
  parameter int PC_IDX = 15
) (
  input logic [NSRC-1:0][RW-1:0] dec_src,
  input logic [NSRC-1:0]         dec_rd_en,
  input logic [RW-1:0]           ex_dst,
  input logic                    ex_we,
  input logic                    ex_load,
  input logic [RW-1:0]           mem_dst,
  input logic                    mem_we,
  input logic                    wb_dst_unused_guard,
  input logic [NSRC-1:0][1:0]    fwd_sel,
  input logic [NSRC-1:0]         pc_rd,
  input logic                    stall_fd,
  input logic                    bubble_ex
);
  localparam logic [RW-1:0] PC_NUM = RW'(PC_IDX);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      assert_pc_never_fwd_R6: assert (!(dec_rd_en[i] && dec_src[i] == PC_NUM) || (fwd_sel[i] == 2'd0 && pc_rd[i]));
      assert_idle_operand_R9: assert (dec_rd_en[i] || (fwd_sel[i] == 2'd0 && !pc_rd[i]));
      assert_ex_sel_source_R1: assert (fwd_sel[i] != 2'd1 || (ex_we && ex_dst == dec_src[i]));
      assert_mem_sel_source_R2: assert (fwd_sel[i] != 2'd2 || (mem_we && mem_dst == dec_src[i]));
      assert_wb_loses_to_mem_R4: assert (fwd_sel[i] != 2'd3 || !(mem_we && mem_dst == dec_src[i]));
    end
    assert_stall_needs_ex_load_R7: assert (!stall_fd || (ex_load && ex_we && ex_dst != PC_NUM));
    assert_bubble_tracks_stall_R7: assert (bubble_ex == stall_fd || wb_dst_unused_guard);
  end
endmodule

bind operand_bypass_ctrl operand_bypass_ctrl_chk #(
  .RW(RW), .NSRC(NSRC), .PC_IDX(PC_IDX)
) u_chk (
  .dec_src(dec_src), .dec_rd_en(dec_rd_en),
  .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load),
  .mem_dst(mem_dst), .mem_we(mem_we),
  .wb_dst_unused_guard(1'b0),
  .fwd_sel(fwd_sel), .pc_rd(pc_rd),
  .stall_fd(stall_fd), .bubble_ex(bubble_ex)
);

// File: tb/operand_bypass_ctrl_bench.sv
module operand_bypass_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0][3:0] dec_src;
  logic [2:0]      dec_rd_en;
  logic [3:0]      ex_dst, mem_dst, wb_dst;
  logic            ex_we, ex_load, mem_we, wb_we;
  logic [2:0][1:0] fwd_sel;
  logic [2:0]      pc_rd;
  logic            stall_fd, bubble_ex;

  operand_bypass_ctrl u_operand_bypass_ctrl (
    .dec_src(dec_src), .dec_rd_en(dec_rd_en),
    .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_we(mem_we),
    .wb_dst(wb_dst), .wb_we(wb_we),
    .fwd_sel(fwd_sel), .pc_rd(pc_rd),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex)
  );

  typedef struct packed {
    logic [3:0] s0, s1, s2;
    logic [2:0] rd;
    logic [3:0] exd; logic exw; logic exl;
    logic [3:0] md;  logic mw;
    logic [3:0] wd;  logic ww;
    logic [5:0] esel;
    logic [2:0] epc;
    logic       est;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R11 no match anywhere
    '{4'd1,4'd2,4'd3,3'b111, 4'd4,1'b1,1'b0, 4'd5,1'b1, 4'd6,1'b1, 6'b000000,3'b000,1'b0},
    // R1 R2 R3 R10 each operand from a different stage
    '{4'd4,4'd5,4'd6,3'b111, 4'd4,1'b1,1'b0, 4'd5,1'b1, 4'd6,1'b1, 6'b111001,3'b000,1'b0},
    // R4 execute beats memory and write-back
    '{4'd7,4'd7,4'd7,3'b111, 4'd7,1'b1,1'b0, 4'd7,1'b1, 4'd7,1'b1, 6'b010101,3'b000,1'b0},
    // R4 memory beats write-back
    '{4'd7,4'd7,4'd7,3'b111, 4'd8,1'b1,1'b0, 4'd7,1'b1, 4'd7,1'b1, 6'b101010,3'b000,1'b0},
    // R5 disabled writers ignored, write-back still wins for op0
    '{4'd7,4'd1,4'd2,3'b111, 4'd7,1'b0,1'b0, 4'd7,1'b0, 4'd7,1'b1, 6'b000011,3'b000,1'b0},
    // R6 source 15 never forwarded even when every stage writes 15
    '{4'd15,4'd1,4'd15,3'b111, 4'd15,1'b1,1'b0, 4'd15,1'b1, 4'd15,1'b1, 6'b000000,3'b101,1'b0},
    // R7 load-use on op1
    '{4'd1,4'd9,4'd3,3'b111, 4'd9,1'b1,1'b1, 4'd5,1'b1, 4'd6,1'b1, 6'b000100,3'b000,1'b1},
    // R7 load-use on op2 only
    '{4'd1,4'd2,4'd9,3'b111, 4'd9,1'b1,1'b1, 4'd5,1'b0, 4'd6,1'b0, 6'b010000,3'b000,1'b1},
    // R9 matching operand not read: no stall, no forward, pc flag clear
    '{4'd9,4'd15,4'd3,3'b100, 4'd9,1'b1,1'b1, 4'd15,1'b1, 4'd6,1'b1, 6'b000000,3'b000,1'b0},
    // R11 load in execute with no consumer
    '{4'd1,4'd2,4'd3,3'b111, 4'd9,1'b1,1'b1, 4'd5,1'b1, 4'd6,1'b1, 6'b000000,3'b000,1'b0},
    // R6 load to 15 read as 15: no stall
    '{4'd15,4'd2,4'd3,3'b111, 4'd15,1'b1,1'b1, 4'd5,1'b1, 4'd6,1'b1, 6'b000000,3'b001,1'b0},
    // R5 load with write-enable low: no stall, memory forward instead
    '{4'd9,4'd2,4'd3,3'b111, 4'd9,1'b0,1'b1, 4'd9,1'b1, 4'd6,1'b1, 6'b000010,3'b000,1'b0},
    // R8 load in memory stage forwards without stall
    '{4'd1,4'd9,4'd9,3'b111, 4'd0,1'b0,1'b0, 4'd9,1'b1, 4'd9,1'b1, 6'b101000,3'b000,1'b0}
  };

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic apply(input vec_t v);
    @(negedge clk);
    dec_src[0] = v.s0; dec_src[1] = v.s1; dec_src[2] = v.s2;
    dec_rd_en = v.rd;
    ex_dst = v.exd; ex_we = v.exw; ex_load = v.exl;
    mem_dst = v.md; mem_we = v.mw;
    wb_dst = v.wd; wb_we = v.ww;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [5:0] esel,
                            input logic [2:0] epc, input logic est);
    compared++;
    if (fwd_sel !== esel || pc_rd !== epc || stall_fd !== est || bubble_ex !== est) begin
      mismatched++;
      $display("FAIL %s: sel=%b pc=%b stall=%b bubble=%b expected sel=%b pc=%b stall=%b bubble=%b",
               req, fwd_sel, pc_rd, stall_fd, bubble_ex, esel, epc, est, est);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    vec_t r;
    // R11 reset state: all inputs low
    r = '0;
    apply(r);
    expect_out("R11 reset", 6'b0, 3'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      expect_out($sformatf("vector %0d", k), VEC[k].esel, VEC[k].epc, VEC[k].est);
    end

    // R7 then R8: load r10 followed by a reader of r10 on op0
    r = '{4'd10,4'd1,4'd2,3'b001, 4'd10,1'b1,1'b1, 4'd3,1'b1, 4'd4,1'b1, 6'b0,3'b0,1'b0};
    apply(r);
    expect_out("R7 load-use stall cycle", 6'b000001, 3'b000, 1'b1);
    // next cycle: decode held, bubble in execute, load now in memory stage
    r.exd = 4'd0; r.exw = 1'b0; r.exl = 1'b0;
    r.md = 4'd10; r.mw = 1'b1; r.wd = 4'd3;
    apply(r);
    expect_out("R8 after stall", 6'b000010, 3'b000, 1'b0);
    // following cycle: reader moved on, new reader sees load at write-back
    r.md = 4'd5; r.wd = 4'd10;
    apply(r);
    expect_out("R3 load at write-back", 6'b000011, 3'b000, 1'b0);

    // R10 R9 all operands read one register but only op1 enabled
    r = '{4'd6,4'd6,4'd6,3'b010, 4'd6,1'b1,1'b0, 4'd6,1'b1, 4'd6,1'b1, 6'b0,3'b0,1'b0};
    apply(r);
    expect_out("R9 single enabled operand", 6'b000100, 3'b000, 1'b0);

    finish_run();
  end
endmodule